// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns the per-machine-cycle requests of an 8-bit controller core into the strobe and port timing of a multiplexed external memory bus. A machine cycle is twelve clocks, or six states of two phases each. During the clock before each cycle starts, the core presents one of four requests: idle, code fetch, data read or data write. Each request carries a 16-bit address, a flag that selects a 16-bit pointer access or an 8-bit indirect access, a table-read flag for code-table reads, and a write byte.

The low address byte and the data byte share one port. The high address byte goes out on a second port. An address latch strobe tells external logic when to capture the low byte. A program-store strobe reads code bytes. Separate read and write strobes serve data memory.

An external-access input chooses whether code fetches go out on the bus or stay internal. A control bit lets software silence the address latch strobe outside external transfers. A filtered reset input restarts the sequencer.

Top module: `mbus_seq`

## Requirements
- R1: A machine cycle lasts exactly 12 clocks, numbered phase slots 0 to 11. `mc_last` is high for the single clock of slot 11. The request inputs are taken at the rising edge that ends slot 11.
- R2: When no data access is in progress and the strobe is enabled, `ale` is high in slots 0-1 and 6-7. That gives two pulses per machine cycle, one every six clocks.
- R3: In a data read or write cycle, `ale` pulses only in slots 0-1; the second pulse is dropped. `psen_n` stays high for the whole cycle.
- R4: In a code fetch with `ea_pin` low (external), `psen_n` is low in slots 2-4 for the byte at the request address and in slots 8-10 for the byte at address+1. Both bytes appear on `rsp_b0` and `rsp_b1`, with `rsp_valid` high for one clock in slot 11.
- R5: In a code fetch with `ea_pin` high (internal), `psen_n` stays high, `p0_oe` stays low and `rsp_valid` stays low.
- R6: While `ale` is high in a fetch or data cycle, `p0_out` carries the low byte of the address being issued: slots 0-1 the request address, slots 6-7 address+1.
- R7: For an external fetch or a 16-bit data access, `p2_out` carries the high byte of the address being issued and `p2_strong` is 1. For an 8-bit indirect access, `p2_out` shows `p2_latch` and `p2_strong` is 0.
- R8: In a read cycle, `rd_n` is low in slots 7-10 and the shared port is released (`p0_oe` = 0). `p0_in` is sampled at the edge where `rd_n` rises, and that byte is returned on `rsp_b0` with `rsp_valid` in slot 11.
- R9: In a write cycle, `wr_n` is low in slots 7-10. The write byte is driven on `p0_out` only while `wr_n` is low. Outside slots 0-1 the port is not driven at any other time. `rd_n` and `wr_n` are never low together.
- R10: Writing control address 8Eh with bit 0 = 1 turns `ale` off in idle cycles and in plain fetches. Data cycles and fetches flagged as table reads still pulse as in R2/R3. Writing bit 0 = 0 restores it. Writes to any other address have no effect.
- R11: When `rst_pin` is high for 24 consecutive clock edges (two machine cycles), `core_rst` goes high and all strobes go inactive. A shorter pulse is ignored. After release, the first `mc_last` comes 12 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | Active-high reset pin, filtered over two machine cycles |
| ea_pin | input | 1 | External-access select: 0 = code fetches go external |
| req_kind | input | 2 | Request: 0 idle, 1 code fetch, 2 data read, 3 data write |
| req_wide | input | 1 | 1 = 16-bit pointer data access, 0 = 8-bit indirect |
| req_tbl | input | 1 | Fetch is a code-table read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| p2_latch | input | 8 | High-port latch contents from the core |
| sfr_we | input | 1 | Control register write strobe |
| sfr_addr | input | 8 | Control register write address |
| sfr_wdata | input | 8 | Control register write data |
| mc_last | output | 1 | High in the last clock of a machine cycle |
| rsp_valid | output | 1 | Returned bytes valid |
| rsp_b0 | output | 8 | First code byte or read data byte |
| rsp_b1 | output | 8 | Second code byte |
| core_rst | output | 1 | Filtered reset to the core |
| p0_out | output | 8 | Shared low address/data port output value |
| p0_oe | output | 1 | Shared port drive enable |
| p0_in | input | 8 | Shared port input value |
| p2_out | output | 8 | High address port value |
| p2_strong | output | 1 | High port carries an address and drives ones strongly |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The hardest case to reach from the ports is the interaction between the strobe-disable bit and the cycle type. `ale` must vanish in idle cycles and plain fetches, yet come back for data cycles and table fetches in the same configuration. The bench reaches this by writing the control register between machine cycles. It then runs idle, plain fetch, table fetch and read cycles back to back, counting rising edges of `ale` in each 12-clock window. A second hard case is a fetch whose second byte crosses a 256-byte page. There the high port must change between the two halves of one cycle. The bench's own address-latching memory model shows this by returning the wrong byte if the high port lags.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned SLOTS  = 12;
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned AW     = 16;
  localparam int unsigned DW     = 8;

  typedef enum logic [1:0] {
    MC_IDLE  = 2'd0,
    MC_FETCH = 2'd1,
    MC_READ  = 2'd2,
    MC_WRITE = 2'd3
  } mc_kind_t;

  typedef struct packed {
    mc_kind_t        kind;
    logic            wide;
    logic            tbl;
    logic            ext;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   wdata;
  } mc_req_t;
endpackage

// File: rtl/mbus_timer.sv
module mbus_timer
  import mbus_pkg::*;
#(
  parameter int unsigned RST_MC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  output logic [SLOT_W-1:0] slot,
  output logic              mc_last,
  output logic              hold
);
  localparam int unsigned LIM = RST_MC * SLOTS;
  localparam int unsigned CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIM);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  assign hold = (cnt_q == LIM_V);

  always_comb begin
    if (!rst_pin)          cnt_d = '0;
    else if (cnt_q == LIM_V) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + CW'(1);

    if (hold)              slot_d = '0;
    else if (slot_q == LAST) slot_d = '0;
    else                   slot_d = slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  assign slot    = slot_q;
  assign mc_last = !hold && (slot_q == LAST);
endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe
  import mbus_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic              hold,
  input  mc_kind_t          kind,
  input  logic              tbl,
  input  logic              ext,
  input  logic              ale_off,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic is_data, ext_code, ale_gate;
  logic win_a, win_b, psen_win, dstb;

  always_comb begin
    is_data  = (kind == MC_READ) || (kind == MC_WRITE);
    ext_code = (kind == MC_FETCH) && ext;
    ale_gate = !ale_off || is_data || ((kind == MC_FETCH) && tbl);
    win_a    = (slot <= 4'd1);
    win_b    = (slot == 4'd6) || (slot == 4'd7);
    psen_win = ((slot >= 4'd2) && (slot <= 4'd4)) ||
               ((slot >= 4'd8) && (slot <= 4'd10));
    dstb     = (slot >= 4'd7) && (slot <= 4'd10);

    ale    = !hold && ale_gate && (win_a || (win_b && !is_data));
    psen_n = !(!hold && ext_code && psen_win);
    rd_n   = !(!hold && (kind == MC_READ) && dstb);
    wr_n   = !(!hold && (kind == MC_WRITE) && dstb);
  end
endmodule

// File: rtl/mbus_port.sv
module mbus_port
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              hold,
  input  mc_kind_t          kind,
  input  logic              wide,
  input  logic              ext,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     p2_latch,
  input  logic [DW-1:0]     p0_in,
  output logic [DW-1:0]     p0_out,
  output logic              p0_oe,
  output logic [DW-1:0]     p2_out,
  output logic              p2_strong,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_b0,
  output logic [DW-1:0]     rsp_b1
);
  logic          is_data, ext_code, second;
  logic [AW-1:0] addr_nx, cur_addr;
  logic          cap0, cap1, vld_d;
  logic [DW-1:0] b0_q, b1_q, b0_d, b1_d;
  logic          vld_q;

  always_comb begin
    is_data  = (kind == MC_READ) || (kind == MC_WRITE);
    ext_code = (kind == MC_FETCH) && ext;
    second   = (slot >= 4'd6);
    addr_nx  = addr + AW'(1);
    cur_addr = (ext_code && second) ? addr_nx : addr;

    p0_oe  = 1'b0;
    p0_out = '0;
    if (!hold) begin
      if ((slot <= 4'd1) && (ext_code || is_data)) begin
        p0_oe  = 1'b1;
        p0_out = cur_addr[DW-1:0];
      end else if (((slot == 4'd6) || (slot == 4'd7)) && ext_code) begin
        p0_oe  = 1'b1;
        p0_out = cur_addr[DW-1:0];
      end else if ((kind == MC_WRITE) && (slot >= 4'd7) && (slot <= 4'd10)) begin
        p0_oe  = 1'b1;
        p0_out = wdata;
      end
    end

    if (!hold && (ext_code || (is_data && wide))) begin
      p2_out    = cur_addr[AW-1:DW];
      p2_strong = 1'b1;
    end else begin
      p2_out    = p2_latch;
      p2_strong = 1'b0;
    end

    cap0  = !hold && ((ext_code && (slot == 4'd4)) ||
                      ((kind == MC_READ) && (slot == 4'd10)));
    cap1  = !hold && ext_code && (slot == 4'd10);
    vld_d = !hold && (slot == 4'd10) && (ext_code || (kind == MC_READ));
    b0_d  = cap0 ? p0_in : b0_q;
    b1_d  = cap1 ? p0_in : b1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0_q  <= '0;
      b1_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      b0_q  <= b0_d;
      b1_q  <= b1_d;
      vld_q <= vld_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_b0    = b0_q;
  assign rsp_b1    = b1_q;
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int unsigned   RST_MC   = 2,
  parameter logic [7:0]    CTL_ADDR = 8'h8E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_pin,
  input  logic        ea_pin,
  input  logic [1:0]  req_kind,
  input  logic        req_wide,
  input  logic        req_tbl,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic [7:0]  p2_latch,
  input  logic        sfr_we,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic        mc_last,
  output logic        rsp_valid,
  output logic [7:0]  rsp_b0,
  output logic [7:0]  rsp_b1,
  output logic        core_rst,
  output logic [7:0]  p0_out,
  output logic        p0_oe,
  input  logic [7:0]  p0_in,
  output logic [7:0]  p2_out,
  output logic        p2_strong,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n
);
  logic [SLOT_W-1:0] slot;
  logic              hold;
  mc_req_t           cyc_q, cyc_d, req_in;
  logic              ale_off_q, ale_off_d;
  logic              sfr_unused;

  assign sfr_unused = ^sfr_wdata[7:1];

  mbus_timer #(.RST_MC(RST_MC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_pin (rst_pin),
    .slot    (slot),
    .mc_last (mc_last),
    .hold    (hold)
  );

  always_comb begin
    req_in.kind  = mc_kind_t'(req_kind);
    req_in.wide  = req_wide;
    req_in.tbl   = req_tbl;
    req_in.ext   = !ea_pin;
    req_in.addr  = req_addr;
    req_in.wdata = req_wdata;

    if (hold) begin
      cyc_d      = '0;
      cyc_d.kind = MC_IDLE;
    end else if (mc_last) begin
      cyc_d = req_in;
    end else begin
      cyc_d = cyc_q;
    end

    if (hold)                                  ale_off_d = 1'b0;
    else if (sfr_we && (sfr_addr == CTL_ADDR)) ale_off_d = sfr_wdata[0];
    else                                       ale_off_d = ale_off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q      <= '0;
      ale_off_q  <= 1'b0;
    end else begin
      cyc_q      <= cyc_d;
      ale_off_q  <= ale_off_d;
    end
  end

  mbus_strobe u_strobe (
    .slot    (slot),
    .hold    (hold),
    .kind    (cyc_q.kind),
    .tbl     (cyc_q.tbl),
    .ext     (cyc_q.ext),
    .ale_off (ale_off_q),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
  );

  mbus_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot),
    .hold      (hold),
    .kind      (cyc_q.kind),
    .wide      (cyc_q.wide),
    .ext       (cyc_q.ext),
    .addr      (cyc_q.addr),
    .wdata     (cyc_q.wdata),
    .p2_latch  (p2_latch),
    .p0_in     (p0_in),
    .p0_out    (p0_out),
    .p0_oe     (p0_oe),
    .p2_out    (p2_out),
    .p2_strong (p2_strong),
    .rsp_valid (rsp_valid),
    .rsp_b0    (rsp_b0),
    .rsp_b1    (rsp_b1)
  );

  assign core_rst = hold;
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic p0_oe,
  input logic rsp_valid,
  input logic mc_last
);
  // R9
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R8
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);

  // R9
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe);

  // R3
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  // R4
  psen_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!psen_n && !rd_n));

  // R1
  mc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_last |=> !mc_last);

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind mbus_seq mbus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .p0_oe     (p0_oe),
  .rsp_valid (rsp_valid),
  .mc_last   (mc_last)
);

// File: tb/mbus_seq_bench.sv
module mbus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_pin = 1'b0;
  logic        ea_pin = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_wide = 1'b0;
  logic        req_tbl = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  p2_latch = '0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic [7:0]  sfr_wdata = '0;
  logic        mc_last, rsp_valid, core_rst, p0_oe, p2_strong;
  logic        ale, psen_n, rd_n, wr_n;
  logic [7:0]  rsp_b0, rsp_b1, p0_out, p0_in, p2_out;

  always #5 clk = ~clk;

  mbus_seq u_mbus_seq (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .ea_pin(ea_pin),
    .req_kind(req_kind), .req_wide(req_wide), .req_tbl(req_tbl),
    .req_addr(req_addr), .req_wdata(req_wdata), .p2_latch(p2_latch),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .mc_last(mc_last), .rsp_valid(rsp_valid), .rsp_b0(rsp_b0),
    .rsp_b1(rsp_b1), .core_rst(core_rst), .p0_out(p0_out),
    .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
    .p2_strong(p2_strong), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  // external memory model with address latch
  logic [7:0]  lat;
  logic [7:0]  dmem [16];
  logic [15:0] ext_addr;

  always_latch if (ale) lat = p0_out;
  assign ext_addr = {p2_out, lat};

  function automatic logic [7:0] code_at(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  assign p0_in = !psen_n ? code_at(ext_addr) :
                 !rd_n   ? dmem[ext_addr[3:0]] : 8'hFF;

  always @(negedge clk) if (!wr_n) dmem[ext_addr[3:0]] <= p0_out;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // per-cycle observations
  int          c_ale, c_psen, c_rd, c_wr, c_stray;
  logic [7:0]  p2_a;
  logic        p2_s, got_v;
  logic [7:0]  got_b0, got_b1;

  task automatic run_mc(input logic [1:0] kind, input logic wide,
                        input logic tbl, input logic [15:0] addr,
                        input logic [7:0] wd);
    logic pa, pp;
    @(negedge clk);
    while (!mc_last) @(negedge clk);
    req_kind = kind; req_wide = wide; req_tbl = tbl;
    req_addr = addr; req_wdata = wd;
    c_ale = 0; c_psen = 0; c_rd = 0; c_wr = 0; c_stray = 0;
    pa = ale; pp = psen_n;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ale && !pa) c_ale++;
      if (!psen_n && pp) c_psen++;
      if (!rd_n) c_rd++;
      if (!wr_n) c_wr++;
      if (p0_oe && i >= 2 && i != 6 && i != 7 && wr_n) c_stray++;
      if (i == 0) begin p2_a = p2_out; p2_s = p2_strong; end
      pa = ale; pp = psen_n;
    end
    got_v = rsp_valid; got_b0 = rsp_b0; got_b1 = rsp_b1;
    req_kind = 2'd0;
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic t_reset_state;
    check(core_rst == 1'b0, "R11", "core_rst after reset", core_rst, 0);
    check(psen_n && rd_n && wr_n, "R9", "strobes idle after reset",
          {psen_n, rd_n, wr_n}, 3'b111);
    check(rsp_valid == 1'b0, "R4", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_idle;
    int n;
    @(negedge clk);
    while (!mc_last) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!mc_last);
    check(n == 12, "R1", "clocks between mc_last", n, 12);
    run_mc(2'd0, 1'b0, 1'b0, 16'h0, 8'h0);
    check(c_ale == 2, "R2", "ale pulses idle", c_ale, 2);
    check(c_psen == 0, "R2", "psen pulses idle", c_psen, 0);
  endtask

  task automatic t_fetch_ext;
    ea_pin = 1'b0;
    run_mc(2'd1, 1'b0, 1'b0, 16'h12FF, 8'h0);
    check(c_psen == 2, "R4", "psen pulses ext fetch", c_psen, 2);
    check(c_ale == 2, "R2", "ale pulses ext fetch", c_ale, 2);
    check(got_v == 1'b1, "R4", "rsp_valid fetch", got_v, 1);
    check(got_b0 == code_at(16'h12FF), "R6", "first code byte",
          got_b0, code_at(16'h12FF));
    check(got_b1 == code_at(16'h1300), "R4", "second code byte page cross",
          got_b1, code_at(16'h1300));
    check(p2_a == 8'h12 && p2_s, "R7", "high port on fetch",
          {p2_s, p2_a}, 9'h112);
  endtask

  task automatic t_fetch_int;
    ea_pin = 1'b1;
    run_mc(2'd1, 1'b0, 1'b0, 16'h0420, 8'h0);
    check(c_psen == 0, "R5", "psen pulses internal fetch", c_psen, 0);
    check(c_stray == 0, "R5", "stray port drive internal fetch", c_stray, 0);
    check(got_v == 1'b0, "R5", "rsp_valid internal fetch", got_v, 0);
    ea_pin = 1'b0;
  endtask

  task automatic t_write_wide;
    run_mc(2'd3, 1'b1, 1'b0, 16'h4A05, 8'h9C);
    check(c_ale == 1, "R3", "ale pulses write", c_ale, 1);
    check(c_psen == 0, "R3", "psen pulses write", c_psen, 0);
    check(c_wr == 4, "R9", "wr low clocks", c_wr, 4);
    check(c_stray == 0, "R9", "port driven outside wr", c_stray, 0);
    check(dmem[5] == 8'h9C, "R9", "written byte", dmem[5], 8'h9C);
    check(p2_a == 8'h4A && p2_s, "R7", "high port wide write",
          {p2_s, p2_a}, 9'h14A);
  endtask

  task automatic t_read_narrow;
    p2_latch = 8'h77;
    run_mc(2'd2, 1'b0, 1'b0, 16'h0005, 8'h0);
    check(c_ale == 1, "R3", "ale pulses read", c_ale, 1);
    check(c_rd == 4, "R8", "rd low clocks", c_rd, 4);
    check(got_v && got_b0 == 8'h9C, "R8", "read byte", {got_v, got_b0}, 9'h19C);
    check(p2_a == 8'h77 && !p2_s, "R7", "high port narrow read",
          {p2_s, p2_a}, 9'h077);
  endtask

  task automatic t_ale_off;
    sfr_write(8'h8F, 8'h01);
    run_mc(2'd0, 1'b0, 1'b0, 16'h0, 8'h0);
    check(c_ale == 2, "R10", "other address ignored", c_ale, 2);
    sfr_write(8'h8E, 8'h01);
    run_mc(2'd0, 1'b0, 1'b0, 16'h0, 8'h0);
    check(c_ale == 0, "R10", "ale off idle", c_ale, 0);
    run_mc(2'd1, 1'b0, 1'b0, 16'h0100, 8'h0);
    check(c_ale == 0, "R10", "ale off plain fetch", c_ale, 0);
    check(c_psen == 2, "R10", "psen kept plain fetch", c_psen, 2);
    run_mc(2'd1, 1'b0, 1'b1, 16'h0200, 8'h0);
    check(c_ale == 2, "R10", "ale on table fetch", c_ale, 2);
    run_mc(2'd2, 1'b0, 1'b0, 16'h0005, 8'h0);
    check(c_ale == 1, "R10", "ale on data read", c_ale, 1);
    sfr_write(8'h8E, 8'h00);
    run_mc(2'd0, 1'b0, 1'b0, 16'h0, 8'h0);
    check(c_ale == 2, "R10", "ale restored", c_ale, 2);
  endtask

  task automatic t_reset_pin;
    int n;
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (10) @(negedge clk);
    check(core_rst == 1'b0, "R11", "short pulse ignored", core_rst, 0);
    rst_pin = 1'b0;
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (30) @(negedge clk);
    check(core_rst == 1'b1, "R11", "long pulse resets", core_rst, 1);
    check(ale == 1'b0 && psen_n, "R11", "strobes quiet in reset",
          {ale, psen_n}, 2'b01);
    rst_pin = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!mc_last);
    check(n == 12, "R11", "first mc_last after release", n, 12);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) dmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_idle();
    t_fetch_ext();
    t_fetch_int();
    t_write_wide();
    t_read_narrow();
    t_ale_off();
    t_reset_pin();
    summary();
  end
endmodule